// File: doc/BRIEF.md
# Receive destination-address filter

This block sits on the receive path of an Ethernet MAC. It watches the destination-address bytes of an incoming frame as they arrive, one byte per valid cycle, and decides whether to keep the frame. A unicast address passes only when it equals the station address. The all-ones broadcast address always passes. A multicast address passes when pass-all-multicast is set, or when hash mode is on and the 64-entry hash table has a one at the slot picked by the address CRC. A receive-all setting overrides every other rule and passes any frame.

The CRC is built up one byte per clock while the address streams in, so the verdict needs no extra pass over the address. It appears one cycle after the sixth byte, as a one-cycle valid strobe. The accept level then stays put until the next frame starts. Frame CRC checking and payload buffering belong to other blocks.

Top module: `rx_da_filter`

## Requirements
- R1: After a synchronous active-low reset, `dec_vld_o` and `accept_o` are 0, and address bytes that arrive before a frame start are ignored.
- R2: A unicast address (bit 0 of byte 0 is 0) is accepted when all 48 bits equal the station address. Byte 0 is `sta_lo_i[7:0]`, byte 3 is `sta_lo_i[31:24]`, byte 4 is `sta_hi_i[7:0]` and byte 5 is `sta_hi_i[15:8]`.
- R3: A unicast address that differs from the station address in any bit is rejected, unless receive-all is set.
- R4: The address FF:FF:FF:FF:FF:FF is accepted whatever the mode inputs and tables hold.
- R5: The hash index is bits [31:26] of a CRC over the six address bytes. The CRC uses polynomial 0x04C11DB7 and an all-ones seed, takes each byte least significant bit first, and has no final inversion. When index bit 5 is 1, the index selects bit [4:0] of `hash_hi_i`.
- R6: When index bit 5 is 0, index bits [4:0] select a bit of `hash_lo_i`.
- R7: A non-broadcast multicast address is rejected when its table bit is 0, and also whenever `hash_en_i` is 0 (unless pass-all-multicast or receive-all is set).
- R8: With `all_mcast_i` set, every multicast address is accepted, and unicast filtering is unchanged.
- R9: With `promisc_i` set, every frame is accepted.
- R10: `dec_vld_o` is high for exactly the one cycle after the cycle that delivers the sixth byte. Mode, station and table inputs are sampled in that sixth-byte cycle. `accept_o` holds its value until the next frame start. Bytes after the sixth, and cycles with `byte_vld_i` low, do not change the result.
- R11: A frame start (`frm_start_i` together with `byte_vld_i`) clears `accept_o` in the next cycle and restarts address collection, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start_i | input | 1 | Marks the current byte as byte 0 of a new frame; used only with `byte_vld_i` |
| byte_vld_i | input | 1 | `byte_i` carries an address byte this cycle |
| byte_i | input | 8 | Destination address byte, byte 0 first |
| promisc_i | input | 1 | Receive-all: accept every frame |
| all_mcast_i | input | 1 | Accept every multicast frame |
| hash_en_i | input | 1 | Enable hash table lookup for multicast |
| sta_lo_i | input | 32 | Station address bytes 0..3, byte 0 in the LSBs |
| sta_hi_i | input | 16 | Station address bytes 4..5, byte 4 in the LSBs |
| hash_lo_i | input | 32 | Hash table entries 0..31 |
| hash_hi_i | input | 32 | Hash table entries 32..63 |
| dec_vld_o | output | 1 | One-cycle strobe: the verdict is ready |
| accept_o | output | 1 | Verdict for the current frame, held until the next start |

## Verification
The station address and the same address with one bit flipped show whether the full 48-bit compare is done, as opposed to a partial one. Two multicast addresses are chosen so that their CRC indices land in the high register and in the low register. Each is run against a table holding only its own bit and against the complement of that table, which checks the register select and the bit select separately. Broadcast with every mode off, pass-all-multicast against a mismatched unicast, and receive-all each isolate one override. Gapped byte streams, trailing bytes and a restart in the middle of a frame exercise the byte counting and the hold-until-start rule.

// File: rtl/rx_da_filter_pkg.sv
// Package for the receive destination-address filter.
// Holds the CRC constants and the one-byte CRC step. Bits are taken LSB first;
// the shift is toward the MSB with no reflection.
package rx_da_filter_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Advance the CRC by eight data bits, LSB of the byte first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc_in,
                                                  input logic [7:0]       data);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/rx_da_capture.sv
// Address capture: counts the address bytes of the current frame and assembles
// them into a 48-bit word, byte 0 in the LSBs.
// Assumes frm_start_i matters only when byte_vld_i is high. The counter rests
// at ADDR_BYTES (idle), so bytes seen before any start are not taken.
module rx_da_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    output logic              start_o,
    output logic              take_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_nxt_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  lane_sel;
    logic [ADDR_W-1:0] addr_q;

    // Qualify the incoming byte: a start always counts, others only until full.
    always_comb begin
        start_o  = byte_vld_i && frm_start_i;
        take_o   = start_o || (byte_vld_i && (cnt_q < CNT_FULL));
        lane_sel = start_o ? '0 : cnt_q;
        cnt_nxt  = start_o ? CNT_W'(1) : (take_o ? cnt_q + CNT_W'(1) : cnt_q);
        last_o   = take_o && (cnt_nxt == CNT_FULL);
    end

    // Steer the byte into its lane; lanes not being written keep their value.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
        assign addr_nxt_o[8*k +: 8] = (take_o && (lane_sel == CNT_W'(k))) ? byte_i
                                                                          : addr_q[8*k +: 8];
    end

    // Byte counter and address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_FULL;
            addr_q <= '0;
        end else begin
            cnt_q  <= cnt_nxt;
            addr_q <= addr_nxt_o;
        end
    end

    // R10: the counter never runs past a full address.
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    // R1: without a start, an idle counter takes nothing.
    p_idle_ignores_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_FULL) && !start_o |-> !take_o);

endmodule

// File: rtl/rx_da_crc.sv
// Running address CRC: seeds at a frame start and advances one byte per taken
// byte. crc_nxt_o already includes the byte of the current cycle, so the last
// byte's CRC is available without waiting an extra cycle.
module rx_da_crc
    import rx_da_filter_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_nxt_o
);

    logic [CRC_W-1:0] crc_q;

    // Fold the current byte into the seed or the running value.
    always_comb begin
        crc_nxt_o = crc_step(start_i ? CRC_SEED : crc_q, byte_i);
    end

    // Hold the running CRC between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_SEED;
        else if (take_i) crc_q <= crc_nxt_o;
    end

    // R10: gaps in the byte stream leave the running CRC unchanged.
    p_crc_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(crc_q));

endmodule

// File: rtl/rx_da_decide.sv
// Verdict logic: on the last address byte, combine the assembled address, the
// CRC-derived hash index and the mode inputs into accept or reject. The result
// is registered, then held until the next frame start.
// Assumes addr_i and crc_i include the byte of the current cycle.
module rx_da_decide #(
    parameter int ADDR_W  = 48,
    parameter int CRC_W   = 32,
    parameter int HASH_W  = 32,
    localparam int IDX_W  = $clog2(2 * HASH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CRC_W-1:0]  crc_i,
    input  logic              promisc_i,
    input  logic              all_mcast_i,
    input  logic              hash_en_i,
    input  logic [ADDR_W-1:0] station_i,
    input  logic [HASH_W-1:0] hash_lo_i,
    input  logic [HASH_W-1:0] hash_hi_i,
    output logic              dec_vld_o,
    output logic              accept_o
);

    logic [IDX_W-1:0]    idx;
    logic [2*HASH_W-1:0] table_w;
    logic                is_mcast;
    logic                is_bcast;
    logic                uc_hit;
    logic                hash_hit;
    logic                verdict;
    logic                accept_q;
    logic                vld_q;

    // Classify the address and look up its hash slot (top index bit picks the register).
    always_comb begin
        idx      = crc_i[CRC_W-1 -: IDX_W];
        table_w  = {hash_hi_i, hash_lo_i};
        is_mcast = addr_i[0];
        is_bcast = &addr_i;
        uc_hit   = !is_mcast && (addr_i == station_i);
        hash_hit = hash_en_i && table_w[idx];
        verdict  = promisc_i || is_bcast || uc_hit ||
                   (is_mcast && (all_mcast_i || hash_hit));
    end

    // Register the verdict on the last byte; a frame start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= last_i;
            if (last_i)       accept_q <= verdict;
            else if (start_i) accept_q <= 1'b0;
        end
    end

    assign dec_vld_o = vld_q;
    assign accept_o  = accept_q;

    // R10: the valid strobe lasts a single cycle.
    p_dec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R10: with neither a start nor a last byte, the verdict holds.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i && !start_i |=> $stable(accept_q));

    // R11: a start that does not also finish the address clears the verdict.
    p_start_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !last_i |=> !accept_q);

    // R4: broadcast always passes.
    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last_i && (&addr_i) |=> accept_q);

    // R9: receive-all passes any frame.
    p_promisc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last_i && promisc_i |=> accept_q);

    // R3: a mismatched unicast fails without receive-all.
    p_uc_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_i && !addr_i[0] && (addr_i != station_i) && !promisc_i |=> !accept_q);

endmodule

// File: rtl/rx_da_filter.sv
// Receive destination-address filter, top level.
// Joins address capture, the running CRC and the verdict logic. Assumes the six
// destination bytes arrive byte 0 first, with frm_start_i on byte 0.
module rx_da_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 32,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int STA_LO_W  = 32,
    localparam int STA_HI_W  = ADDR_W - STA_LO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_start_i,
    input  logic                byte_vld_i,
    input  logic [7:0]          byte_i,
    input  logic                promisc_i,
    input  logic                all_mcast_i,
    input  logic                hash_en_i,
    input  logic [STA_LO_W-1:0] sta_lo_i,
    input  logic [STA_HI_W-1:0] sta_hi_i,
    input  logic [HASH_W-1:0]   hash_lo_i,
    input  logic [HASH_W-1:0]   hash_hi_i,
    output logic                dec_vld_o,
    output logic                accept_o
);

    import rx_da_filter_pkg::*;

    logic              start_w;
    logic              take_w;
    logic              last_w;
    logic [ADDR_W-1:0] addr_w;
    logic [CRC_W-1:0]  crc_w;
    logic [ADDR_W-1:0] station_w;

    assign station_w = {sta_hi_i, sta_lo_i};

    rx_da_capture #(.ADDR_BYTES(ADDR_BYTES)) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_start_i(frm_start_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .start_o    (start_w),
        .take_o     (take_w),
        .last_o     (last_w),
        .addr_nxt_o (addr_w)
    );

    rx_da_crc crc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .take_i   (take_w),
        .byte_i   (byte_i),
        .crc_nxt_o(crc_w)
    );

    rx_da_decide #(
        .ADDR_W(ADDR_W),
        .CRC_W (CRC_W),
        .HASH_W(HASH_W)
    ) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .last_i     (last_w),
        .addr_i     (addr_w),
        .crc_i      (crc_w),
        .promisc_i  (promisc_i),
        .all_mcast_i(all_mcast_i),
        .hash_en_i  (hash_en_i),
        .station_i  (station_w),
        .hash_lo_i  (hash_lo_i),
        .hash_hi_i  (hash_hi_i),
        .dec_vld_o  (dec_vld_o),
        .accept_o   (accept_o)
    );

endmodule

// File: tb/rx_da_filter_tb_top.sv
// Bench for rx_da_filter. A behavioural model that counts and scores bytes is
// compared with the outputs on every clock, shortly after the rising edge.
module rx_da_filter_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef logic [7:0] bq_t[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic        promisc_i = 1'b0;
    logic        all_mcast_i = 1'b0;
    logic        hash_en_i = 1'b0;
    logic [31:0] sta_lo_i = 32'h0;
    logic [15:0] sta_hi_i = 16'h0;
    logic [31:0] hash_lo_i = 32'h0;
    logic [31:0] hash_hi_i = 32'h0;
    logic        dec_vld_o;
    logic        accept_o;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    rx_da_filter dut_i (
        .clk(clk), .rst_n(rst_n), .frm_start_i(frm_start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .promisc_i(promisc_i), .all_mcast_i(all_mcast_i),
        .hash_en_i(hash_en_i), .sta_lo_i(sta_lo_i), .sta_hi_i(sta_hi_i),
        .hash_lo_i(hash_lo_i), .hash_hi_i(hash_hi_i),
        .dec_vld_o(dec_vld_o), .accept_o(accept_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference hash index: bit-serial CRC over a 48-bit address, byte 0 first.
    function automatic int ref_idx(input logic [47:0] a);
        int unsigned c = 32'hFFFF_FFFF;
        for (int n = 0; n < 48; n++) begin
            bit fb = c[31] ^ a[n];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return int'(c >> 26);
    endfunction

    function automatic bit ref_accept(input logic [47:0] a);
        int idx;
        logic [63:0] tbl;
        if (promisc_i) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
        if (a[0] == 1'b0) return (a == {sta_hi_i, sta_lo_i});
        if (all_mcast_i) return 1'b1;
        if (!hash_en_i) return 1'b0;
        idx = ref_idx(a);
        tbl = {hash_hi_i, hash_lo_i};
        return tbl[idx];
    endfunction

    // Model: byte count, assembled address, expected outputs.
    int          m_cnt = 6;
    logic [47:0] m_addr = '0;
    logic        m_vld = 1'b0;
    logic        m_acc = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 6;
            m_vld = 1'b0;
            m_acc = 1'b0;
        end else begin
            m_vld = 1'b0;
            if (byte_vld_i && frm_start_i) begin
                m_cnt = 0;
                m_acc = 1'b0;
            end
            if (byte_vld_i && m_cnt < 6) begin
                m_addr[8*m_cnt +: 8] = byte_i;
                m_cnt++;
                if (m_cnt == 6) begin
                    m_acc = ref_accept(m_addr);
                    m_vld = 1'b1;
                end
            end
        end
    end

    // Compare on every clock, after the edge has settled.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            n_vec++;
            if (dec_vld_o !== m_vld || accept_o !== m_acc) begin
                n_fail++;
                $display("FAIL %s t=%0t: dec_vld=%b accept=%b, expected dec_vld=%b accept=%b",
                         cur_req, $time, dec_vld_o, accept_o, m_vld, m_acc);
            end
        end
    end

    function automatic bq_t to_bytes(input logic [47:0] a);
        bq_t q;
        for (int k = 0; k < 6; k++) q.push_back(a[8*k +: 8]);
        return q;
    endfunction

    // Send bytes; the first carries the start flag, with 'gap' idle cycles between bytes.
    task automatic send(input bq_t b, input int gap, input bit with_start);
        for (int i = 0; i < b.size(); i++) begin
            @(negedge clk);
            frm_start_i = with_start && (i == 0);
            byte_vld_i  = 1'b1;
            byte_i      = b[i];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                frm_start_i = 1'b0;
                byte_vld_i  = 1'b0;
                byte_i      = 8'hA5;
            end
        end
        @(negedge clk);
        frm_start_i = 1'b0;
        byte_vld_i  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic modes(input bit p, input bit am, input bit he);
        @(negedge clk);
        promisc_i = p; all_mcast_i = am; hash_en_i = he;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] st;
        logic [47:0] mc_hi;
        logic [47:0] mc_lo;
        bit got_hi;
        bit got_lo;
        bq_t q;
        int ih;
        int il;
        got_hi = 1'b0;
        got_lo = 1'b0;
        mc_hi = '0;
        mc_lo = '0;
        st = 48'h5544_3322_1102;       // byte 0 = 0x02, unicast
        sta_lo_i = st[31:0];
        sta_hi_i = st[47:32];

        // R1: reset holds outputs low; stray bytes before a start are ignored.
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        send(to_bytes(st), 0, 1'b0);

        // R2: exact station match, back to back and with gaps.
        cur_req = "R2";
        send(to_bytes(st), 0, 1'b1);
        send(to_bytes(st), 2, 1'b1);

        // R3: one bit off in the last byte, and in byte 0.
        cur_req = "R3";
        send(to_bytes(st ^ 48'h8000_0000_0000), 0, 1'b1);
        send(to_bytes(st ^ 48'h0000_0000_0002), 0, 1'b1);

        // R4: broadcast with every mode off and empty tables.
        cur_req = "R4";
        send(to_bytes(48'hFFFF_FFFF_FFFF), 0, 1'b1);

        // Find multicast addresses whose index falls in each register.
        for (int k = 0; k < 256; k++) begin
            logic [47:0] a;
            a = {8'(k), 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
            if (ref_idx(a) >= 32 && !got_hi) begin mc_hi = a; got_hi = 1'b1; end
            if (ref_idx(a) <  32 && !got_lo) begin mc_lo = a; got_lo = 1'b1; end
        end
        ih = ref_idx(mc_hi);
        il = ref_idx(mc_lo);

        // R5: high register select.
        cur_req = "R5";
        modes(1'b0, 1'b0, 1'b1);
        hash_hi_i = 32'h1 << (ih - 32);
        hash_lo_i = 32'h0;
        send(to_bytes(mc_hi), 0, 1'b1);
        hash_lo_i = 32'hFFFF_FFFF;
        hash_hi_i = ~(32'h1 << (ih - 32));
        send(to_bytes(mc_hi), 0, 1'b1);

        // R6: low register select.
        cur_req = "R6";
        hash_hi_i = 32'h0;
        hash_lo_i = 32'h1 << il;
        send(to_bytes(mc_lo), 1, 1'b1);
        hash_hi_i = 32'hFFFF_FFFF;
        hash_lo_i = ~(32'h1 << il);
        send(to_bytes(mc_lo), 1, 1'b1);

        // R7: a full table with hashing off rejects multicast.
        cur_req = "R7";
        hash_hi_i = 32'hFFFF_FFFF;
        hash_lo_i = 32'hFFFF_FFFF;
        modes(1'b0, 1'b0, 1'b0);
        send(to_bytes(mc_hi), 0, 1'b1);
        send(to_bytes(mc_lo), 0, 1'b1);

        // R8: pass-all multicast with an empty table; unicast rule unchanged.
        cur_req = "R8";
        hash_hi_i = 32'h0;
        hash_lo_i = 32'h0;
        modes(1'b0, 1'b1, 1'b0);
        send(to_bytes(mc_lo), 0, 1'b1);
        send(to_bytes(st ^ 48'h0000_0100_0000), 0, 1'b1);

        // R9: receive-all accepts a foreign unicast.
        cur_req = "R9";
        modes(1'b1, 1'b0, 1'b0);
        send(to_bytes(48'h0102_0304_0500), 0, 1'b1);
        modes(1'b0, 1'b0, 1'b0);

        // R10: trailing bytes after the sixth do not disturb the held verdict.
        cur_req = "R10";
        q = to_bytes(st);
        q.push_back(8'hFF); q.push_back(8'hFF); q.push_back(8'h00);
        send(q, 1, 1'b1);
        repeat (5) @(negedge clk);

        // R11: broadcast accepted, then a restart partway into a frame.
        cur_req = "R11";
        send(to_bytes(48'hFFFF_FFFF_FFFF), 0, 1'b1);
        q = '{8'h02, 8'h11, 8'h22};
        send(q, 0, 1'b1);
        send(to_bytes(st ^ 48'h0000_0000_0100), 0, 1'b1);
        send(to_bytes(st), 0, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule